// File: doc/BRIEF.md
# Vector Control and Status Register File

This block holds the control and status registers of a vector unit: the element start index, the vector length, the vector type word, the read-only byte length of a vector register, and a three-bit combined control word. The combined word packs a two-bit fixed-point rounding mode above a one-bit saturation flag. Two further CSR addresses give narrow views onto the combined word's fields. They have no storage of their own, so a write through one view changes only its own field.

A CSR unit presents a 12-bit address, a write enable and write data each cycle. The block answers at once with the current read value, the value that a write in this cycle will leave in the register, and an illegal-access flag for unknown addresses. The fixed-point datapath reads the rounding mode and saturation flag directly. It can also raise the saturation flag through a set request, which yields to a CSR write that targets the saturation field in the same cycle.

Top module: `vec_csr_file`

## Requirements
- R1: The legal addresses are 0x008 (start index), 0x009 (saturation view), 0x00A (rounding view), 0x00F (combined word), 0xC20 (length), 0xC21 (type) and 0xC22 (byte length). Any other address raises `csrIllegal` in the same cycle, reads 0 and returns 0 as the write result. A write to such an address changes no register.
- R2: In the combined word, bits [2:1] hold the rounding mode and bit [0] holds the saturation flag. A write to 0x00F loads the rounding mode from data bits [2:1] and the flag from data bit [0]. A read of 0x00F returns {rounding, flag}, zero-extended to XLEN.
- R3: A write to 0x009 loads the saturation flag from data bit [0] and leaves the rounding mode unchanged.
- R4: A write to 0x00A loads the rounding mode from data bits [1:0] and leaves the saturation flag unchanged.
- R5: A read of 0x009 returns the flag in bit 0, and a read of 0x00A returns the rounding mode in bits [1:0]. All other bits read 0.
- R6: The start index is 16 bits wide. A write keeps only data bits [log2(VLEN)-1:0] and clears the bits above them.
- R7: The length (0xC20) and type (0xC21) registers store and return all XLEN bits written.
- R8: 0xC22 always reads VLEN/8. Writes to it change nothing.
- R9: `csrRdData` shows the addressed register's value before any write in the current cycle. `csrWrResult` shows the value that register holds after the write at the next clock edge. Both are combinational.
- R10: After reset, the start index, length, rounding mode and saturation flag are 0. The type register holds 1 in bit XLEN-1 (the illegal-configuration bit) and 0 in every other bit, which covers the mask-agnostic bit 7 and the reserved field.
- R11: When `satSetIn` is high, the saturation flag is 1 after the next edge. The exception is a write to 0x009 or 0x00F in the same cycle: that write sets the flag's value. A write to 0x00A does not block the set request.
- R12: `roundMode` and `satFlag` always equal the stored rounding mode and saturation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrAddr | input | 12 | CSR address |
| csrWrEn | input | 1 | Write enable for the addressed CSR |
| csrWrData | input | XLEN | Write data |
| satSetIn | input | 1 | Saturation set request from the datapath |
| csrRdData | output | XLEN | Current value of the addressed CSR |
| csrWrResult | output | XLEN | Value the addressed CSR holds after this cycle's write |
| csrIllegal | output | 1 | Address is not one of the seven CSRs |
| roundMode | output | 2 | Current rounding mode to the datapath |
| satFlag | output | 1 | Current saturation flag to the datapath |

## Verification
The bench builds the block with XLEN = 32 and VLEN = 128. With these values the start-index mask is 7 bits wide, so random data with bits set between 7 and 15 checks that the upper bits are cleared. The byte-length constant is 16, which the bench can tell apart from any value it writes. XLEN = 32 puts the type register's illegal-configuration bit at bit 31, above every other field. Directed cycles cover the two alias writes, a set request colliding with each alias write, and writes to unlisted addresses next to the legal ones.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

  localparam logic [11:0] ADDR_START = 12'h008;
  localparam logic [11:0] ADDR_SAT   = 12'h009;
  localparam logic [11:0] ADDR_RND   = 12'h00A;
  localparam logic [11:0] ADDR_CMB   = 12'h00F;
  localparam logic [11:0] ADDR_LEN   = 12'hC20;
  localparam logic [11:0] ADDR_TYPE  = 12'hC21;
  localparam logic [11:0] ADDR_LENB  = 12'hC22;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_START,
    SEL_SAT,
    SEL_RND,
    SEL_CMB,
    SEL_LEN,
    SEL_TYPE,
    SEL_LENB
  } csrSel_e;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic    wrStart;
    logic    wrSat;
    logic    wrRnd;
    logic    wrLen;
    logic    wrType;
    csrSel_e sel;
  } csrStrobe_t;

endpackage

// File: rtl/vcsr_ctrl.sv
module vcsr_ctrl
  import vcsr_pkg::*;
(
  input  logic       [11:0] csrAddr,
  input  logic              csrWrEn,
  output csrStrobe_t        strobe,
  output logic              csrIllegal
);

  csrSel_e sel;

  always_comb begin
    case (csrAddr)
      ADDR_START: sel = SEL_START;
      ADDR_SAT:   sel = SEL_SAT;
      ADDR_RND:   sel = SEL_RND;
      ADDR_CMB:   sel = SEL_CMB;
      ADDR_LEN:   sel = SEL_LEN;
      ADDR_TYPE:  sel = SEL_TYPE;
      ADDR_LENB:  sel = SEL_LENB;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.sel     = sel;
    // the combined word drives both field strobes; each alias drives one
    strobe.wrStart = csrWrEn && (sel == SEL_START);
    strobe.wrSat   = csrWrEn && ((sel == SEL_SAT) || (sel == SEL_CMB));
    strobe.wrRnd   = csrWrEn && ((sel == SEL_RND) || (sel == SEL_CMB));
    strobe.wrLen   = csrWrEn && (sel == SEL_LEN);
    strobe.wrType  = csrWrEn && (sel == SEL_TYPE);
    csrIllegal     = (sel == SEL_NONE);
  end

endmodule

// File: rtl/vcsr_dpath.sv
module vcsr_dpath
  import vcsr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [XLEN-1:0]   csrWrData,
  input  logic              satSetIn,
  output logic [XLEN-1:0]   csrRdData,
  output logic [XLEN-1:0]   csrWrResult,
  output logic [1:0]        roundMode,
  output logic              satFlag
);

  localparam int START_W = 16;
  localparam int IDX_W   = $clog2(VLEN);
  localparam int LENB    = VLEN / 8;
  localparam logic [XLEN-1:0] TYPE_RST = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] LENB_VAL = XLEN'(LENB);

  logic [START_W-1:0] startIdx, startNext;
  logic [XLEN-1:0]    lenReg, typeReg;
  logic [1:0]         rndReg, rndNext;
  logic               satReg, satNext;

  // start index keeps only the element-index bits
  always_comb begin
    startNext = '0;
    startNext[IDX_W-1:0] = csrWrData[IDX_W-1:0];
  end

  // rounding source depends on which view is written
  always_comb begin
    rndNext = (strobe.sel == SEL_CMB) ? csrWrData[2:1] : csrWrData[1:0];
  end

  // CSR write to the flag outranks the datapath set request
  always_comb begin
    if (strobe.wrSat)  satNext = csrWrData[0];
    else if (satSetIn) satNext = 1'b1;
    else               satNext = satReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startIdx <= '0;
      lenReg   <= '0;
      typeReg  <= TYPE_RST;
      rndReg   <= '0;
      satReg   <= 1'b0;
    end else begin
      if (strobe.wrStart) startIdx <= startNext;
      if (strobe.wrLen)   lenReg   <= csrWrData;
      if (strobe.wrType)  typeReg  <= csrWrData;
      if (strobe.wrRnd)   rndReg   <= rndNext;
      satReg <= satNext;
    end
  end

  always_comb begin
    csrRdData = '0;
    case (strobe.sel)
      SEL_START: csrRdData[START_W-1:0] = startIdx;
      SEL_SAT:   csrRdData[0]           = satReg;
      SEL_RND:   csrRdData[1:0]         = rndReg;
      SEL_CMB:   csrRdData[2:0]         = {rndReg, satReg};
      SEL_LEN:   csrRdData              = lenReg;
      SEL_TYPE:  csrRdData              = typeReg;
      SEL_LENB:  csrRdData              = LENB_VAL;
      default:   csrRdData              = '0;
    endcase
  end

  always_comb begin
    csrWrResult = '0;
    case (strobe.sel)
      SEL_START: csrWrResult[START_W-1:0] = startNext;
      SEL_SAT:   csrWrResult[0]           = csrWrData[0];
      SEL_RND:   csrWrResult[1:0]         = csrWrData[1:0];
      SEL_CMB:   csrWrResult[2:0]         = csrWrData[2:0];
      SEL_LEN:   csrWrResult              = csrWrData;
      SEL_TYPE:  csrWrResult              = csrWrData;
      SEL_LENB:  csrWrResult              = LENB_VAL;
      default:   csrWrResult              = '0;
    endcase
  end

  assign roundMode = rndReg;
  assign satFlag   = satReg;

endmodule

// File: rtl/vec_csr_file.sv
module vec_csr_file
  import vcsr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [11:0]     csrAddr,
  input  logic            csrWrEn,
  input  logic [XLEN-1:0] csrWrData,
  input  logic            satSetIn,
  output logic [XLEN-1:0] csrRdData,
  output logic [XLEN-1:0] csrWrResult,
  output logic            csrIllegal,
  output logic [1:0]      roundMode,
  output logic            satFlag
);

  csrStrobe_t strobe;

  vcsr_ctrl u_ctrl (
    .csrAddr    (csrAddr),
    .csrWrEn    (csrWrEn),
    .strobe     (strobe),
    .csrIllegal (csrIllegal)
  );

  vcsr_dpath #(.XLEN(XLEN), .VLEN(VLEN)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .csrWrData   (csrWrData),
    .satSetIn    (satSetIn),
    .csrRdData   (csrRdData),
    .csrWrResult (csrWrResult),
    .roundMode   (roundMode),
    .satFlag     (satFlag)
  );

endmodule

// File: rtl/vcsr_chk.sv
module vcsr_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [11:0]     csrAddr,
  input logic            csrWrEn,
  input logic [XLEN-1:0] csrWrData,
  input logic            satSetIn,
  input logic [XLEN-1:0] csrRdData,
  input logic [XLEN-1:0] csrWrResult,
  input logic            csrIllegal,
  input logic [1:0]      roundMode,
  input logic            satFlag
);

  // R2
  cmb_read_packs_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == 12'h00F) |-> (csrRdData == XLEN'({roundMode, satFlag})));

  // R3
  sat_view_keeps_rnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 12'h009) |=> (roundMode == $past(roundMode)));

  // R4
  rnd_view_keeps_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 12'h00A && !satSetIn) |=> (satFlag == $past(satFlag)));

  // R11
  sat_write_beats_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 12'h009 && satSetIn) |=> (satFlag == $past(csrWrData[0])));

  // R11
  sat_set_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satSetIn && !(csrWrEn && (csrAddr == 12'h009 || csrAddr == 12'h00F))) |=> satFlag);

  // R1
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (csrRdData == '0 && csrWrResult == '0));

  // R1
  illegal_write_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrIllegal && csrWrEn && !satSetIn) |=> ($stable(roundMode) && $stable(satFlag)));

endmodule

bind vec_csr_file vcsr_chk #(.XLEN(XLEN)) u_vcsr_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrAddr     (csrAddr),
  .csrWrEn     (csrWrEn),
  .csrWrData   (csrWrData),
  .satSetIn    (satSetIn),
  .csrRdData   (csrRdData),
  .csrWrResult (csrWrResult),
  .csrIllegal  (csrIllegal),
  .roundMode   (roundMode),
  .satFlag     (satFlag)
);

// File: tb/test_vec_csr_file.sv
module test_vec_csr_file;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int IDX_W = $clog2(VLEN);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [11:0]     csrAddr = '0;
  logic            csrWrEn = 1'b0;
  logic [XLEN-1:0] csrWrData = '0;
  logic            satSetIn = 1'b0;
  logic [XLEN-1:0] csrRdData, csrWrResult;
  logic            csrIllegal;
  logic [1:0]      roundMode;
  logic            satFlag;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0]     mStart;
  logic [XLEN-1:0] mLen, mType;
  logic [1:0]      mRnd;
  logic            mSat;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_csr_file #(.XLEN(XLEN), .VLEN(VLEN)) i_vec_csr_file (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .satSetIn(satSetIn), .csrRdData(csrRdData),
    .csrWrResult(csrWrResult), .csrIllegal(csrIllegal),
    .roundMode(roundMode), .satFlag(satFlag)
  );

  function automatic bit isLegal(logic [11:0] a);
    return a == 12'h008 || a == 12'h009 || a == 12'h00A || a == 12'h00F ||
           a == 12'hC20 || a == 12'hC21 || a == 12'hC22;
  endfunction

  function automatic logic [XLEN-1:0] expRd(logic [11:0] a);
    case (a)
      12'h008: return XLEN'(mStart);
      12'h009: return XLEN'(mSat);
      12'h00A: return XLEN'(mRnd);
      12'h00F: return XLEN'({mRnd, mSat});
      12'hC20: return mLen;
      12'hC21: return mType;
      12'hC22: return XLEN'(VLEN / 8);
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] expRes(logic [11:0] a, logic [XLEN-1:0] d);
    case (a)
      12'h008: return XLEN'(d[IDX_W-1:0]);
      12'h009: return XLEN'(d[0]);
      12'h00A: return XLEN'(d[1:0]);
      12'h00F: return XLEN'(d[2:0]);
      12'hC20: return d;
      12'hC21: return d;
      12'hC22: return XLEN'(VLEN / 8);
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(logic [11:0] a);
    case (a)
      12'h008: return "R6";
      12'h009: return "R3";
      12'h00A: return "R4";
      12'h00F: return "R2";
      12'hC20: return "R7";
      12'hC21: return "R7";
      12'hC22: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic resetModel();
    mStart = '0; mLen = '0; mRnd = '0; mSat = 1'b0;
    mType  = {1'b1, {(XLEN-1){1'b0}}};
  endtask

  // one cycle: drive, check combinational outputs, clock, update the model
  task automatic step(logic [11:0] a, logic we, logic [XLEN-1:0] d, logic ss);
    @(negedge clk);
    csrAddr = a; csrWrEn = we; csrWrData = d; satSetIn = ss;
    #1;
    chk({reqOf(a), "/R9 read"}, csrRdData, expRd(a));
    chk("R1 illegal", XLEN'(csrIllegal), XLEN'(!isLegal(a)));
    if (we) chk({reqOf(a), "/R9 result"}, csrWrResult, expRes(a, d));
    chk("R12 roundMode", XLEN'(roundMode), XLEN'(mRnd));
    chk("R12 satFlag", XLEN'(satFlag), XLEN'(mSat));
    @(posedge clk);
    if (we) begin
      case (a)
        12'h008: mStart = 16'(d[IDX_W-1:0]);
        12'h00A: mRnd = d[1:0];
        12'h00F: mRnd = d[2:1];
        12'hC20: mLen = d;
        12'hC21: mType = d;
        default: ;
      endcase
    end
    if (we && (a == 12'h009 || a == 12'h00F)) mSat = d[0];
    else if (ss) mSat = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [11:0] legalList [7];
    legalList = '{12'h008, 12'h009, 12'h00A, 12'h00F, 12'hC20, 12'hC21, 12'hC22};
    void'($urandom(32'd4242));
    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10 reset state, read at every address
    foreach (legalList[i]) step(legalList[i], 1'b0, '0, 1'b0);

    // R2 combined write
    step(12'h00F, 1'b1, 32'hFFFF_FFFD, 1'b0);
    step(12'h00F, 1'b0, '0, 1'b0);
    // R4 rounding view keeps flag, R5 reads
    step(12'h00A, 1'b1, 32'hFFFF_FFF2, 1'b0);
    step(12'h009, 1'b0, '0, 1'b0);
    step(12'h00A, 1'b0, '0, 1'b0);
    // R3 flag view keeps rounding
    step(12'h009, 1'b1, 32'hFFFF_FFFE, 1'b0);
    step(12'h00F, 1'b0, '0, 1'b0);
    // R11 set alone, then write to flag view beating set
    step(12'hC20, 1'b0, '0, 1'b1);
    step(12'h009, 1'b1, 32'h0, 1'b1);
    step(12'h00F, 1'b0, '0, 1'b0);
    // R11 combined write beats set; rounding view write does not
    step(12'h00F, 1'b1, 32'h6, 1'b1);
    step(12'h00A, 1'b1, 32'h1, 1'b1);
    step(12'h00F, 1'b0, '0, 1'b0);
    // R6 start index truncation
    step(12'h008, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(12'h008, 1'b0, '0, 1'b0);
    // R7 full-width length/type, R8 byte length write ignored
    step(12'hC20, 1'b1, 32'hDEAD_BEEF, 1'b0);
    step(12'hC21, 1'b1, 32'h1234_5678, 1'b0);
    step(12'hC22, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(12'hC22, 1'b0, '0, 1'b0);
    // R1 neighbours of legal addresses, written then state read back
    step(12'h00B, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(12'h007, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(12'hC23, 1'b1, 32'hFFFF_FFFF, 1'b0);
    foreach (legalList[i]) step(legalList[i], 1'b0, '0, 1'b0);

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a;
      int pick = $urandom_range(0, 8);
      if (pick < 7) a = legalList[pick];
      else a = 12'($urandom);
      step(a, 1'($urandom_range(0, 1)), $urandom, ($urandom_range(0, 5) == 0));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule